// File: doc/BRIEF.md
# Word Group Transposer

The block takes a wide vector made of equal-width words and reorders the words by transposing their group structure. The input vector is read as `NUM_GROUPS` groups placed one after another, each with `WORDS_PER_GROUP` words. The output vector is read as `WORDS_PER_GROUP` groups, each with `NUM_GROUPS` words. In effect, the words are interleaved. It is the usual way to turn a block of per-channel sample runs into one interleaved stream of samples, and to turn such a stream back into runs.

The input vector is qualified by a valid flag. The reordered vector is captured in an output register one clock later and carries its own valid flag. Swapping the two group parameters gives the inverse mapping. So two of these blocks in series, the second built with the parameters swapped, give back the original vector. The word width and both group counts are fixed when the block is built.

Top module: `word_shuffle`

## Requirements
- R1: Word 0 sits in the least-significant `WORD_W` bits of each vector. Output word `j*NUM_GROUPS + i` equals input word `i*WORDS_PER_GROUP + j`. For 3 groups of 2 words, input words [A B a b 1 2] (word 0 first) come out as [A a 1 B b 2].
- R2: `outValid` is high in the cycle after a clock edge at which `inValid` was high, and low in the cycle after an edge at which it was low.
- R3: `outData` loads only at clock edges where `inValid` is high. At every other edge it keeps its value, whatever `inData` carries.
- R4: While `rstN` is low, `outValid` and `outData` are held at zero.
- R5: A block built with (`NUM_GROUPS`=A, `WORDS_PER_GROUP`=B) followed by one built with (B, A) returns the original vector, two cycles after it entered.
- R6: With either group parameter equal to 1, the output vector equals the input vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input vector qualifier |
| inData | input | NUM_GROUPS*WORDS_PER_GROUP*WORD_W | Input vector, word 0 in the low bits |
| outValid | output | 1 | Output vector qualifier |
| outData | output | NUM_GROUPS*WORDS_PER_GROUP*WORD_W | Reordered vector, registered |

## Verification
The block has only one register stage, so any wrong internal state shows at the ports on the very next cycle. A wrong index in the transpose puts a word in the wrong lane of `outData`. A stuck or free-running load strobe either misses a new vector or overwrites a held one. A broken valid register puts `outValid` out of step with `inValid`. The sweep drives many distinct word patterns through a 3x2 block, a 1x5 identity block and a 2x3 inverse block fed by the first. Each lane is compared against its index computed in the bench. Idle cycles with changing data are placed between the vectors, to check that the output holds.

// File: rtl/word_shuffle_pkg.sv
package word_shuffle_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic loadVec;   // capture the shuffled vector at this edge
    logic clearVec;  // force the output register to zero
  } shuffleCtrl_t;

  // Flat index of input word for output lane (group j, word i).
  function automatic int unsigned srcIndex(
    input int unsigned outLane,
    input int unsigned numGroups,
    input int unsigned wordsPerGroup
  );
    int unsigned grp;
    int unsigned pos;
    grp = outLane / numGroups;   // j
    pos = outLane % numGroups;   // i
    return pos * wordsPerGroup + grp;
  endfunction

endpackage

// File: rtl/word_shuffle_ctrl.sv
module word_shuffle_ctrl
  import word_shuffle_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output shuffleCtrl_t ctrl,
  output logic         outValid
);

  logic validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else begin
      validQ <= inValid;
    end
  end

  always_comb begin
    ctrl.loadVec  = inValid;
    ctrl.clearVec = 1'b0;
  end

  assign outValid = validQ;

endmodule

// File: rtl/word_shuffle_datapath.sv
module word_shuffle_datapath
  import word_shuffle_pkg::*;
#(
  parameter int unsigned WORD_W          = 8,
  parameter int unsigned NUM_GROUPS      = 3,
  parameter int unsigned WORDS_PER_GROUP = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  shuffleCtrl_t        ctrl,
  input  logic [VEC_W-1:0]    inData,
  output logic [VEC_W-1:0]    outData
);

  localparam int unsigned NUM_WORDS = NUM_GROUPS * WORDS_PER_GROUP;
  localparam int unsigned VEC_W     = NUM_WORDS * WORD_W;

  logic [VEC_W-1:0] shuffled;
  logic [VEC_W-1:0] vecQ;

  // Output lane j*NUM_GROUPS+i takes input word i*WORDS_PER_GROUP+j.
  for (genvar grpOut = 0; grpOut < WORDS_PER_GROUP; grpOut++) begin : gOutGroup
    for (genvar posOut = 0; posOut < NUM_GROUPS; posOut++) begin : gOutWord
      localparam int unsigned DST = grpOut * NUM_GROUPS + posOut;
      localparam int unsigned SRC = srcIndex(DST, NUM_GROUPS, WORDS_PER_GROUP);
      assign shuffled[DST*WORD_W +: WORD_W] = inData[SRC*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecQ <= '0;
    end else if (ctrl.clearVec) begin
      vecQ <= '0;
    end else if (ctrl.loadVec) begin
      vecQ <= shuffled;
    end
  end

  assign outData = vecQ;

endmodule

// File: rtl/word_shuffle.sv
module word_shuffle
  import word_shuffle_pkg::*;
#(
  parameter int unsigned WORD_W          = 8,
  parameter int unsigned NUM_GROUPS      = 3,
  parameter int unsigned WORDS_PER_GROUP = 2
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  logic                                          inValid,
  input  logic [NUM_GROUPS*WORDS_PER_GROUP*WORD_W-1:0]  inData,
  output logic                                          outValid,
  output logic [NUM_GROUPS*WORDS_PER_GROUP*WORD_W-1:0]  outData
);

  shuffleCtrl_t ctrl;

  word_shuffle_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  word_shuffle_datapath #(
    .WORD_W          (WORD_W),
    .NUM_GROUPS      (NUM_GROUPS),
    .WORDS_PER_GROUP (WORDS_PER_GROUP)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/word_shuffle_checker.sv
module word_shuffle_checker #(
  parameter int unsigned WORD_W          = 8,
  parameter int unsigned NUM_GROUPS      = 3,
  parameter int unsigned WORDS_PER_GROUP = 2
) (
  input logic                                         clk,
  input logic                                         rstN,
  input logic                                         inValid,
  input logic [NUM_GROUPS*WORDS_PER_GROUP*WORD_W-1:0] inData,
  input logic                                         outValid,
  input logic [NUM_GROUPS*WORDS_PER_GROUP*WORD_W-1:0] outData
);

  localparam int unsigned LAST = NUM_GROUPS * WORDS_PER_GROUP - 1;

  // R2: valid follows input valid by one cycle
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R3: no load without valid
  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outData));

  // R1: first and last words are fixed points of the transpose
  assert_corner_words_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (outData[WORD_W-1:0] == $past(inData[WORD_W-1:0])) &&
                (outData[LAST*WORD_W +: WORD_W] == $past(inData[LAST*WORD_W +: WORD_W])));

  // R4: leaving reset, outputs are zero
  assert_reset_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && outData == '0));

endmodule

bind word_shuffle word_shuffle_checker #(
  .WORD_W          (WORD_W),
  .NUM_GROUPS      (NUM_GROUPS),
  .WORDS_PER_GROUP (WORDS_PER_GROUP)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inData   (inData),
  .outValid (outValid),
  .outData  (outData)
);

// File: tb/word_shuffle_bench.sv
`timescale 1ns/1ps
module word_shuffle_bench;

  localparam int W   = 8;
  localparam int NG  = 3;
  localparam int WPG = 2;
  localparam int N   = NG * WPG;
  localparam int IDN = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic           inValid = 1'b0;
  logic [N*W-1:0] inData = '0;
  logic           outValid;
  logic [N*W-1:0] outData;

  logic           invValid;
  logic [N*W-1:0] invData;

  logic             idValid = 1'b0;
  logic [IDN*W-1:0] idIn = '0;
  logic             idOutValid;
  logic [IDN*W-1:0] idOut;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  word_shuffle #(.WORD_W(W), .NUM_GROUPS(NG), .WORDS_PER_GROUP(WPG)) u_word_shuffle (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData));

  // inverse: 2 groups of 3 words undoes 3 groups of 2 words
  word_shuffle #(.WORD_W(W), .NUM_GROUPS(WPG), .WORDS_PER_GROUP(NG)) u_word_shuffle_inv (
    .clk(clk), .rstN(rstN), .inValid(outValid), .inData(outData),
    .outValid(invValid), .outData(invData));

  word_shuffle #(.WORD_W(W), .NUM_GROUPS(1), .WORDS_PER_GROUP(IDN)) u_word_shuffle_id (
    .clk(clk), .rstN(rstN), .inValid(idValid), .inData(idIn),
    .outValid(idOutValid), .outData(idOut));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] wordVal(input int seed, input int k);
    return W'((seed * 37 + k * 101 + 5) ^ (seed >> 2));
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [N*W-1:0] sent;
    logic [N*W-1:0] expShuf;
    logic [IDN*W-1:0] idSent;
    repeat (3) @(negedge clk);
    check("R4 outValid in reset", 64'(outValid), 64'd0);
    check("R4 outData in reset", 64'(outData), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R4 outValid after reset", 64'(outValid), 64'd0);
    check("R4 outData after reset", 64'(outData), 64'd0);

    // fixed example: [A B a b 1 2] -> [A a 1 B b 2]
    inData = {8'h02, 8'h01, 8'hBB, 8'hAA, 8'h0B, 8'h0A};
    inValid = 1'b1;
    @(negedge clk);
    check("R1 example vector", 64'(outData), 64'({8'h02, 8'hBB, 8'h0B, 8'h01, 8'hAA, 8'h0A}));
    check("R2 valid high", 64'(outValid), 64'd1);
    inValid = 1'b0;
    @(negedge clk);

    for (int seed = 0; seed < 200; seed++) begin
      for (int k = 0; k < N; k++) sent[k*W +: W] = wordVal(seed, k);
      for (int g = 0; g < NG; g++)
        for (int w = 0; w < WPG; w++)
          expShuf[(w*NG + g)*W +: W] = sent[(g*WPG + w)*W +: W];
      for (int k = 0; k < IDN; k++) idSent[k*W +: W] = wordVal(seed + 7, k);
      inData = sent;
      inValid = 1'b1;
      idIn = idSent;
      idValid = 1'b1;
      @(negedge clk);
      check("R1 transpose", 64'(outData), 64'(expShuf));
      check("R2 valid after input", 64'(outValid), 64'd1);
      check("R6 identity", 64'(idOut), 64'(idSent));
      inValid = 1'b0;
      idValid = 1'b0;
      inData = ~sent;
      idIn = ~idSent;
      @(negedge clk);
      check("R3 hold while idle", 64'(outData), 64'(expShuf));
      check("R2 valid drops", 64'(outValid), 64'd0);
      check("R5 inverse restores", 64'(invData), 64'(sent));
      check("R5 inverse valid", 64'(invValid), 64'd1);
      check("R3 identity hold", 64'(idOut), 64'(idSent));
    end

    // mid-run reset clears state
    rstN = 1'b0;
    @(negedge clk);
    check("R4 outData cleared", 64'(outData), 64'd0);
    check("R4 outValid cleared", 64'(outValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule